// File: doc/BRIEF.md
# SCSI Bus-Master DMA Channel Registers

This block holds the register set of a SCSI host adapter's bus-master DMA channel and tracks the progress of a transfer. Software programs a byte count, a memory address and a descriptor-list address into three start registers. It then writes a command word whose low two bits pick one of four operations. A start operation copies the start registers into their working counterparts, clears the status flags and turns on the DMA path. Idle turns the path off. Abort sends a one-cycle cancel pulse to the SCSI core. Blast is accepted and does nothing.

The data mover reports each burst on a transfer port. The block checks the burst's direction against the command word, clips the length to the remaining count and returns the clipped length in the same cycle. It then counts down the working count, advances the working address, and raises a done flag when the count reaches zero. A level input selects how status flags are cleared: by writing ones, or by reading the status word. The SCSI core's interrupt line shows in the status word as it is read and is never stored.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset the command, working count and status words read 0, the working address reads 0xFFFFFFFF, the working descriptor address reads 0xFFFFFFFD and dma_en_o is 0.
- R2: Word offset 0 (command), 1 (start count), 2 (start address) and 6 (start descriptor address) store the full written word and read it back.
- R3: Writes to offset 3 (working count), 4 (working address), 7 (working descriptor address) and to the status offset 5 while read-clear mode is on leave the registers unchanged.
- R4: A command write with bits [1:0]=3 (start) loads working count, address and descriptor address from offsets 1, 2 and 6, clears status bits 0 to 5 and sets dma_en_o on the next edge.
- R5: Command bits [1:0]=0 (idle) clear dma_en_o. Bits [1:0]=1 (blast) leave dma_en_o and all working registers unchanged.
- R6: Command bits [1:0]=2 (abort) raise cancel_o for exactly the one cycle after the write.
- R7: A transfer with xfer_valid_i high and a matching direction returns min(xfer_len_i, working count) on xfer_len_o in the same cycle. At the next edge the working count drops by that amount and the working address rises by it.
- R8: Status bit 3 (done) is set when an accepted transfer leaves the working count at zero.
- R9: Command bit 7 gives the direction (1 = device to memory, which must match xfer_to_mem_i=1). A mismatched transfer gives xfer_ok_o=0 and xfer_len_o=0 and changes no register.
- R10: With rd_clear_mode_i low, a write to status offset 5 clears those of bits 1 (error), 2 (abort) and 3 (done) that are written as 1.
- R11: With rd_clear_mode_i high, writes to status are ignored. A status read returns the current value, and bits 1 to 3 clear at the following edge.
- R12: Status bit 4 reads as 1 while scsi_irq_i is high, and reads as 0 once scsi_irq_i falls.
- R13: A pulse on cmd_done_i forces the working count to zero and sets done.
- R14: A start command in the same cycle as an accepted transfer wins: the working count takes the start count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, combinational from reg_addr_i |
| rd_clear_mode_i | input | 1 | 1: status clears on read; 0: status clears on write-1 |
| scsi_irq_i | input | 1 | SCSI core interrupt level |
| cmd_done_i | input | 1 | SCSI command completion pulse |
| xfer_valid_i | input | 1 | Transfer request strobe |
| xfer_to_mem_i | input | 1 | Transfer direction, 1 = device to memory |
| xfer_len_i | input | LW | Requested byte count |
| xfer_ok_o | output | 1 | Request accepted (direction matches) |
| xfer_len_o | output | LW | Clipped byte count granted |
| dma_en_o | output | 1 | DMA path enabled |
| cancel_o | output | 1 | Request-cancel pulse toward the SCSI core |

## Verification
The bench builds the block with its defaults: 32-bit registers and a 16-bit transfer length. With these widths the two address reset patterns can be checked bit for bit. A single 16-bit request can also exceed a small working count, so the clip, the exact run to zero and the resulting done flag all occur within a few bursts. Both status clearing modes, the interrupt overlay, completion and the start-versus-transfer collision are each reached in a few directed cycles.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  typedef enum logic [2:0] {
    OFS_CMD  = 3'd0,
    OFS_SCNT = 3'd1,
    OFS_SADR = 3'd2,
    OFS_WCNT = 3'd3,
    OFS_WADR = 3'd4,
    OFS_STAT = 3'd5,
    OFS_SDSC = 3'd6,
    OFS_WDSC = 3'd7
  } reg_ofs_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } chan_op_e;

  localparam int CMD_DIR_BIT = 7;
  localparam int STW        = 6;
  localparam int ST_PWDN    = 0;
  localparam int ST_ERR     = 1;
  localparam int ST_ABT     = 2;
  localparam int ST_DONE    = 3;
  localparam int ST_SINT    = 4;
  localparam int ST_MISM    = 5;
  localparam logic [STW-1:0] ST_CLR_MASK = 6'b001110;
endpackage

// File: rtl/dma_cmd_ctl.sv
module dma_cmd_ctl
  import scsi_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic [DW-1:0] cmd_q_o,
  output logic          start_o,
  output logic          dma_en_o,
  output logic          cancel_o
);
  chan_op_e op;
  assign op      = chan_op_e'(cmd_wdata_i[1:0]);
  assign start_o = cmd_we_i && (op == OP_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q_o  <= '0;
      dma_en_o <= 1'b0;
      cancel_o <= 1'b0;
    end else begin
      cancel_o <= cmd_we_i && (op == OP_ABORT);
      if (cmd_we_i) begin
        cmd_q_o <= cmd_wdata_i;
        unique case (op)
          OP_IDLE:  dma_en_o <= 1'b0;
          OP_START: dma_en_o <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  // R6
  cancel_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> $past(cmd_we_i && cmd_wdata_i[1:0] == 2'd2));

  // R4
  en_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> dma_en_o);

  // R5
  blast_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_wdata_i[1:0] == 2'd1) |=> $stable(dma_en_o));
endmodule

// File: rtl/dma_xfer_track.sv
module dma_xfer_track #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] scnt_i,
  input  logic [DW-1:0] sadr_i,
  input  logic [DW-1:0] sdsc_i,
  input  logic          done_cmd_i,
  input  logic          dir_cmd_i,
  input  logic          xfer_valid_i,
  input  logic          xfer_to_mem_i,
  input  logic [LW-1:0] xfer_len_i,
  output logic [DW-1:0] wcnt_o,
  output logic [DW-1:0] wadr_o,
  output logic [DW-1:0] wdsc_o,
  output logic          xfer_ok_o,
  output logic [LW-1:0] xfer_len_o,
  output logic          hit_zero_o
);
  localparam logic [DW-1:0] WADR_RST = '1;
  localparam logic [DW-1:0] WDSC_RST = ~DW'(2);

  logic [DW-1:0] len_ext, clip;

  assign len_ext    = DW'(xfer_len_i);
  assign xfer_ok_o  = xfer_valid_i && (xfer_to_mem_i == dir_cmd_i);
  assign clip       = (wcnt_o < len_ext) ? wcnt_o : len_ext;
  assign xfer_len_o = xfer_ok_o ? clip[LW-1:0] : '0;
  assign hit_zero_o = !start_i && xfer_ok_o && (wcnt_o == clip);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_o <= '0;
      wadr_o <= WADR_RST;
      wdsc_o <= WDSC_RST;
    end else if (start_i) begin
      wcnt_o <= scnt_i;
      wadr_o <= sadr_i;
      wdsc_o <= sdsc_i;
    end else begin
      if (xfer_ok_o) wadr_o <= wadr_o + clip;
      if (done_cmd_i)     wcnt_o <= '0;
      else if (xfer_ok_o) wcnt_o <= wcnt_o - clip;
    end
  end

  // R9
  misdir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_i && (xfer_to_mem_i != dir_cmd_i) && !start_i && !done_cmd_i)
      |=> ($stable(wcnt_o) && $stable(wadr_o)));

  // R7
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_ok_o && !start_i && !done_cmd_i)
      |=> (wcnt_o == $past(wcnt_o) - DW'($past(xfer_len_o))));

  // R7
  clip_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_len_o <= xfer_len_i);

  // R13
  complete_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_cmd_i && !start_i) |=> (wcnt_o == '0));

  // R14
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (wcnt_o == $past(scnt_i)));
endmodule

// File: rtl/dma_status_reg.sv
module dma_status_reg
  import scsi_dma_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           set_done_i,
  input  logic           wr_i,
  input  logic [STW-1:0] wdata_i,
  input  logic           rd_i,
  input  logic           rc_mode_i,
  output logic [STW-1:0] stat_o
);
  logic [STW-1:0] clr;

  always_comb begin
    clr = '0;
    if (wr_i && !rc_mode_i) clr = wdata_i & ST_CLR_MASK;
    if (rd_i && rc_mode_i)  clr = clr | ST_CLR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
    end else if (start_i) begin
      stat_o <= '0;
    end else begin
      stat_o <= (stat_o & ~clr) | (set_done_i ? STW'(1 << ST_DONE) : '0);
    end
  end

  // R8
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_done_i && !start_i) |=> stat_o[ST_DONE]);

  // R11
  ro_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rc_mode_i && !rd_i && !start_i && !set_done_i) |=> $stable(stat_o));

  // R4
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (stat_o == '0));
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
  import scsi_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          rd_clear_mode_i,
  input  logic          scsi_irq_i,
  input  logic          cmd_done_i,
  input  logic          xfer_valid_i,
  input  logic          xfer_to_mem_i,
  input  logic [LW-1:0] xfer_len_i,
  output logic          xfer_ok_o,
  output logic [LW-1:0] xfer_len_o,
  output logic          dma_en_o,
  output logic          cancel_o
);
  localparam int NSTART = 3;
  localparam logic [2:0] START_OFS [NSTART] = '{OFS_SCNT, OFS_SADR, OFS_SDSC};

  logic [DW-1:0]  start_q [NSTART];
  logic [DW-1:0]  cmd_q, wcnt, wadr, wdsc;
  logic [STW-1:0] stat_q, stat_view;
  logic           start, hit_zero, stat_wr, stat_rd;

  for (genvar g = 0; g < NSTART; g++) begin : g_start
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  start_q[g] <= '0;
      else if (reg_we_i && reg_addr_i == START_OFS[g]) start_q[g] <= reg_wdata_i;
    end
  end

  dma_cmd_ctl #(.DW(DW)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (reg_we_i && reg_addr_i == OFS_CMD),
    .cmd_wdata_i (reg_wdata_i),
    .cmd_q_o     (cmd_q),
    .start_o     (start),
    .dma_en_o    (dma_en_o),
    .cancel_o    (cancel_o)
  );

  dma_xfer_track #(.DW(DW), .LW(LW)) u_xfer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .scnt_i        (start_q[0]),
    .sadr_i        (start_q[1]),
    .sdsc_i        (start_q[2]),
    .done_cmd_i    (cmd_done_i),
    .dir_cmd_i     (cmd_q[CMD_DIR_BIT]),
    .xfer_valid_i  (xfer_valid_i),
    .xfer_to_mem_i (xfer_to_mem_i),
    .xfer_len_i    (xfer_len_i),
    .wcnt_o        (wcnt),
    .wadr_o        (wadr),
    .wdsc_o        (wdsc),
    .xfer_ok_o     (xfer_ok_o),
    .xfer_len_o    (xfer_len_o),
    .hit_zero_o    (hit_zero)
  );

  assign stat_wr = reg_we_i && reg_addr_i == OFS_STAT;
  assign stat_rd = reg_re_i && reg_addr_i == OFS_STAT;

  dma_status_reg u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .set_done_i (hit_zero || cmd_done_i),
    .wr_i       (stat_wr),
    .wdata_i    (reg_wdata_i[STW-1:0]),
    .rd_i       (stat_rd),
    .rc_mode_i  (rd_clear_mode_i),
    .stat_o     (stat_q)
  );

  // interrupt is a read-time overlay only
  always_comb begin
    stat_view          = stat_q;
    stat_view[ST_SINT] = stat_q[ST_SINT] | scsi_irq_i;
  end

  always_comb begin
    unique case (reg_ofs_e'(reg_addr_i))
      OFS_CMD:  reg_rdata_o = cmd_q;
      OFS_SCNT: reg_rdata_o = start_q[0];
      OFS_SADR: reg_rdata_o = start_q[1];
      OFS_WCNT: reg_rdata_o = wcnt;
      OFS_WADR: reg_rdata_o = wadr;
      OFS_STAT: reg_rdata_o = DW'(stat_view);
      OFS_SDSC: reg_rdata_o = start_q[2];
      default:  reg_rdata_o = wdsc;
    endcase
  end

  // R3
  wk_wr_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_WDSC) |=> $stable(wdsc));

  // R12
  irq_overlay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scsi_irq_i && reg_addr_i == OFS_STAT) |-> reg_rdata_o[ST_SINT]);
endmodule

// File: tb/scsi_dma_chan_bench.sv
`timescale 1ns/1ps
module scsi_dma_chan_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 0, reg_re_i = 0, rd_clear_mode_i = 0, scsi_irq_i = 0;
  logic        cmd_done_i = 0, xfer_valid_i = 0, xfer_to_mem_i = 0;
  logic [2:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic [15:0] xfer_len_i = 0, xfer_len_o;
  logic        xfer_ok_o, dma_en_o, cancel_o;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  scsi_dma_chan u_scsi_dma_chan (.*);

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-check, 2 transfer-check
    logic [2:0]  ofs;
    logic [31:0] dat;  // transfer: bit16 dir, [15:0] length
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd1, 32'h0000_0100, 32'h0, 4'd2},   // R2
    '{2'd0, 3'd2, 32'h0000_1000, 32'h0, 4'd2},
    '{2'd0, 3'd6, 32'h0000_2000, 32'h0, 4'd2},
    '{2'd1, 3'd1, 32'h0,         32'h0000_0100, 4'd2},
    '{2'd0, 3'd0, 32'h0000_0003, 32'h0, 4'd4},   // R4
    '{2'd1, 3'd3, 32'h0,         32'h0000_0100, 4'd4},
    '{2'd1, 3'd4, 32'h0,         32'h0000_1000, 4'd4},
    '{2'd1, 3'd7, 32'h0,         32'h0000_2000, 4'd4},
    '{2'd2, 3'd0, 32'h0000_0040, 32'h0000_0040, 4'd7}, // R7
    '{2'd1, 3'd3, 32'h0,         32'h0000_00C0, 4'd7},
    '{2'd1, 3'd4, 32'h0,         32'h0000_1040, 4'd7},
    '{2'd2, 3'd0, 32'h0001_0010, 32'h0,         4'd9}, // R9
    '{2'd1, 3'd3, 32'h0,         32'h0000_00C0, 4'd9},
    '{2'd2, 3'd0, 32'h0000_0200, 32'h0000_00C0, 4'd7}, // clip
    '{2'd1, 3'd3, 32'h0,         32'h0,         4'd7},
    '{2'd1, 3'd5, 32'h0,         32'h0000_0008, 4'd8}, // R8
    '{2'd0, 3'd5, 32'h0000_0008, 32'h0,         4'd10}, // R10
    '{2'd1, 3'd5, 32'h0,         32'h0,         4'd10},
    '{2'd0, 3'd3, 32'h0000_0055, 32'h0,         4'd3}, // R3
    '{2'd1, 3'd3, 32'h0,         32'h0,         4'd3}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_re_i = 1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 0;
  endtask

  task automatic rchk(input string rq, input logic [2:0] a, input logic [31:0] e);
    logic [31:0] d;
    rd(a, d);
    chk(rq, d, e);
  endtask

  task automatic xf(input logic dir, input logic [15:0] len, output logic [15:0] got);
    @(negedge clk_i);
    xfer_valid_i = 1; xfer_to_mem_i = dir; xfer_len_i = len;
    #1 got = xfer_len_o;
    @(negedge clk_i);
    xfer_valid_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] g;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    // R1 reset state
    rchk("R1", 3'd0, 32'h0);
    rchk("R1", 3'd3, 32'h0);
    rchk("R1", 3'd4, 32'hFFFF_FFFF);
    rchk("R1", 3'd7, 32'hFFFF_FFFD);
    rchk("R1", 3'd5, 32'h0);
    chk("R1", 32'(dma_en_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: wr(VECS[i].ofs, VECS[i].dat);
        2'd1: rchk($sformatf("R%0d", VECS[i].rq), VECS[i].ofs, VECS[i].exp);
        default: begin
          xf(VECS[i].dat[16], VECS[i].dat[15:0], g);
          chk($sformatf("R%0d", VECS[i].rq), 32'(g), VECS[i].exp);
        end
      endcase
    end

    chk("R4", 32'(dma_en_o), 32'h1);
    wr(3'd0, 32'h1);                    // blast
    chk("R5", 32'(dma_en_o), 32'h1);
    rchk("R5", 3'd4, 32'h0000_1100);
    wr(3'd0, 32'h0);                    // idle
    chk("R5", 32'(dma_en_o), 32'h0);
    rchk("R2", 3'd0, 32'h0);

    wr(3'd0, 32'h2);                    // abort
    chk("R6", 32'(cancel_o), 32'h1);
    @(negedge clk_i);
    chk("R6", 32'(cancel_o), 32'h0);

    // direction device-to-memory, run to zero
    wr(3'd1, 32'h10);
    wr(3'd0, 32'h83);
    xf(1'b0, 16'h4, g);
    chk("R9", 32'(g), 32'h0);
    xf(1'b1, 16'h10, g);
    chk("R7", 32'(g), 32'h10);
    rchk("R8", 3'd5, 32'h8);

    // R11 read-clear mode
    rd_clear_mode_i = 1;
    wr(3'd5, 32'h8);
    rchk("R11", 3'd5, 32'h8);
    rchk("R11", 3'd5, 32'h0);
    rd_clear_mode_i = 0;

    // R12 interrupt overlay
    scsi_irq_i = 1;
    rchk("R12", 3'd5, 32'h10);
    scsi_irq_i = 0;
    rchk("R12", 3'd5, 32'h0);

    // R13 completion
    wr(3'd1, 32'h20);
    wr(3'd0, 32'h3);
    rchk("R13", 3'd3, 32'h20);
    @(negedge clk_i) cmd_done_i = 1;
    @(negedge clk_i) cmd_done_i = 0;
    rchk("R13", 3'd3, 32'h0);
    rchk("R13", 3'd5, 32'h8);

    // R14 start collides with transfer
    wr(3'd1, 32'h30);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 32'h3;
    xfer_valid_i = 1; xfer_to_mem_i = 0; xfer_len_i = 16'h5;
    @(negedge clk_i);
    reg_we_i = 0; xfer_valid_i = 0;
    rchk("R14", 3'd3, 32'h30);
    rchk("R14", 3'd5, 32'h0);

    finish_run();
  end
endmodule